// File: doc/BRIEF.md
# Multi-Mode Pixel Color Lookup Path

This block turns one pixel per clock into three 8-bit color words for a downstream set of converters. Each clock it takes three 8-bit pixel ports (red, green, blue) and a 4-bit overlay code. A mode register chooses how the pixel bits are read. Three modes look the color up in per-channel 256-entry palettes: 24-bit true color, 8-bit pseudo color, and a 15-bit mode that uses only the upper 32 palette entries. Three bypass modes drive the outputs straight from the pixel bits: full 24-bit, 15-bit 5-5-5 and 8-bit 3-3-2.

A nonzero overlay code replaces the pixel with one of fifteen overlay colors. A pixel read mask is ANDed with the pixel bytes before palette addressing, but only in the 24-bit and 8-bit palette modes. Palettes, mask, control and overlay colors are all loaded through one write-only host port. Every mode has the same fixed output latency, so pixel timing never depends on the mode.

Top module: `color_lookup_path`

## Requirements
- R1: After reset all three color outputs are zero. A pixel presented before clock edge k appears on the outputs after edge k+1 and not after edge k, in every mode.
- R2: Mode code 0 (24-bit palette): each output equals its own channel's palette entry, addressed by that channel's masked input byte.
- R3: Mode code 1 (24-bit bypass): the outputs equal the red, green and blue input bytes. The palettes and the mask have no effect.
- R4: Mode code 2 (8-bit pseudo color): one masked byte addresses all three palettes. Control bits 7:6 choose the source port: 00 is red, 01 is green, 10 or 11 is blue.
- R5: Mode code 3 (8-bit bypass): the port chosen as in R4 is split 3-3-2. Bits 7:5 go to red bits 7:5, bits 4:2 go to green bits 7:5, and bits 1:0 go to blue bits 7:6. All other output bits are zero, and the mask has no effect.
- R6: Mode code 5 (15-bit bypass): red input bit 7 is ignored. Red input bits 6:2 form the red field, red bits 1:0 followed by green bits 7:5 form the green field, and green bits 4:0 form the blue field. Each field drives output bits 7:3, and output bits 2:0 are zero.
- R7: Mode code 4 (15-bit palette): the three R6 fields each address their own channel's palette at 224 plus the field (entries 224 to 255). The mask has no effect.
- R8: The mask resets to 0xFF. It applies in mode codes 0 and 2 only.
- R9: An overlay code from 1 to 15 outputs that overlay's stored color, whatever the mode. Code 0 passes the pixel path through.
- R10: Host writes take effect for a pixel presented in the cycle after the write. The address map is:
  - 0x000-0x0FF: red palette.
  - 0x100-0x1FF: green palette.
  - 0x200-0x2FF: blue palette.
  - 0x300: mask.
  - 0x301: control. Bits 2:0 are the mode and bits 7:6 are the port select.
  - 0x300 + 4*code + channel: overlay colors, with channel 0, 1 or 2 for red, green or blue.
  - Addresses from 0x340 to 0x3FF are ignored.
- R11: Mode codes 6 and 7 behave as 24-bit bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pix_r_i | input | 8 | Red pixel port |
| pix_g_i | input | 8 | Green pixel port |
| pix_b_i | input | 8 | Blue pixel port |
| ovl_i | input | 4 | Overlay code, 0 = none |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 10 | Host write address |
| wr_data_i | input | 8 | Host write data |
| col_r_o | output | 8 | Red color word |
| col_g_o | output | 8 | Green color word |
| col_b_o | output | 8 | Blue color word |

## Verification
Some rules are checked by assertions on every cycle. In 24-bit bypass the first stage copies the inputs. In the 3-3-2 and 5-5-5 bypass formats the low output bits are zero. The 15-bit palette addresses stay in the top 32 entries. In the mask-using modes no address bit survives outside the mask. A nonzero overlay code always replaces the color.

Other behaviour can only be shown by the bench's scenarios:
- the palette contents actually returned;
- the port selection and the exact field packing;
- the two-cycle latency;
- that writes land at the decoded address and that addresses at 0x340 and above are ignored.

// File: rtl/pxl_pkg.sv
package pxl_pkg;
  localparam int PIX_W  = 8;
  localparam int OVL_W  = 4;
  localparam int ADDR_W = 10;
  localparam int NCH    = 3;
  localparam int NOVL   = 2 ** OVL_W;
  localparam int DEPTH  = 2 ** PIX_W;
  localparam int F15_W  = 5;

  localparam logic [2:0] MODE_TC24    = 3'd0;
  localparam logic [2:0] MODE_BYP24   = 3'd1;
  localparam logic [2:0] MODE_PSEUDO8 = 3'd2;
  localparam logic [2:0] MODE_BYP8    = 3'd3;
  localparam logic [2:0] MODE_PAL15   = 3'd4;
  localparam logic [2:0] MODE_BYP15   = 3'd5;

  typedef logic [NCH-1:0][PIX_W-1:0] rgb_t;
endpackage

// File: rtl/pxl_host_regs.sv
module pxl_host_regs
  import pxl_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_en_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [PIX_W-1:0]            wr_data_i,
  output logic [NCH-1:0]              pal_we_o,
  output logic [PIX_W-1:0]            mask_o,
  output logic [2:0]                  mode_o,
  output logic [1:0]                  port_sel_o,
  output rgb_t [NOVL-1:0]             ovl_o
);
  localparam logic [1:0] REG_PAGE = 2'(NCH);

  logic             reg_hit;
  logic [OVL_W-1:0] code;
  logic [1:0]       chan;

  for (genvar c = 0; c < NCH; c++) begin : g_we
    assign pal_we_o[c] = wr_en_i && (wr_addr_i[ADDR_W-1 -: 2] == 2'(c));
  end

  assign reg_hit = wr_en_i && (wr_addr_i[ADDR_W-1 -: 2] == REG_PAGE)
                   && (wr_addr_i[ADDR_W-3 -: 2] == 2'b00);
  assign code    = wr_addr_i[OVL_W+1:2];
  assign chan    = wr_addr_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o     <= '1;
      mode_o     <= MODE_TC24;
      port_sel_o <= 2'd0;
      ovl_o      <= '0;
    end else if (reg_hit) begin
      if (code == '0) begin
        if (chan == 2'd0) mask_o <= wr_data_i;
        if (chan == 2'd1) begin
          mode_o     <= wr_data_i[2:0];
          port_sel_o <= wr_data_i[PIX_W-1 -: 2];
        end
      end else if (chan != 2'd3) begin
        ovl_o[code][chan] <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/pxl_palette.sv
module pxl_palette
  import pxl_pkg::*;
(
  input  logic             clk_i,
  input  logic [NCH-1:0]   we_i,
  input  logic [PIX_W-1:0] wa_i,
  input  logic [PIX_W-1:0] wd_i,
  input  rgb_t             ra_i,
  output rgb_t             rd_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [PIX_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i[c]) mem[wa_i] <= wd_i;
    end
    assign rd_o[c] = mem[ra_i[c]];
  end
endmodule

// File: rtl/pxl_format.sv
module pxl_format
  import pxl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] r_i,
  input  logic [PIX_W-1:0] g_i,
  input  logic [PIX_W-1:0] b_i,
  input  logic [OVL_W-1:0] ovl_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       port_sel_i,
  input  logic [PIX_W-1:0] mask_i,
  output rgb_t             d_o,
  output logic             use_pal_o,
  output logic [OVL_W-1:0] ovl_o
);
  localparam int PAD15 = PIX_W - F15_W;

  logic [PIX_W-1:0] sel;
  logic [F15_W-1:0] f_r, f_g, f_b;
  rgb_t             nx_d;
  logic             nx_pal;

  always_comb begin
    sel = (port_sel_i == 2'd0) ? r_i : (port_sel_i == 2'd1) ? g_i : b_i;
    f_r = r_i[6:2];
    f_g = {r_i[1:0], g_i[7:5]};
    f_b = g_i[4:0];
    nx_pal = 1'b0;
    nx_d   = {b_i, g_i, r_i};
    case (mode_i)
      MODE_TC24: begin
        nx_pal = 1'b1;
        nx_d   = {b_i & mask_i, g_i & mask_i, r_i & mask_i};
      end
      MODE_PSEUDO8: begin
        nx_pal = 1'b1;
        nx_d   = {3{sel & mask_i}};
      end
      MODE_BYP8: nx_d = {{sel[1:0], 6'b0}, {sel[4:2], 5'b0}, {sel[7:5], 5'b0}};
      MODE_PAL15: begin
        nx_pal = 1'b1;
        nx_d   = {{{PAD15{1'b1}}, f_b}, {{PAD15{1'b1}}, f_g}, {{PAD15{1'b1}}, f_r}};
      end
      MODE_BYP15: nx_d = {{f_b, {PAD15{1'b0}}}, {f_g, {PAD15{1'b0}}}, {f_r, {PAD15{1'b0}}}};
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o       <= '0;
      use_pal_o <= 1'b0;
      ovl_o     <= '0;
    end else begin
      d_o       <= nx_d;
      use_pal_o <= nx_pal;
      ovl_o     <= ovl_i;
    end
  end

  a_r3_byp24_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYP24) |=> (!use_pal_o && d_o[0] == $past(r_i)
                                && d_o[1] == $past(g_i) && d_o[2] == $past(b_i)));

  a_r5_byp8_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYP8) |=> (!use_pal_o && d_o[0][4:0] == '0
                               && d_o[1][4:0] == '0 && d_o[2][5:0] == '0));

  a_r6_byp15_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_BYP15) |=> (!use_pal_o && d_o[0][2:0] == '0
                                && d_o[1][2:0] == '0 && d_o[2][2:0] == '0));

  a_r7_pal15_top32: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_PAL15) |=> (use_pal_o && d_o[0][7:5] == 3'b111
                                && d_o[1][7:5] == 3'b111 && d_o[2][7:5] == 3'b111));

  a_r8_mask_applied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_TC24 || mode_i == MODE_PSEUDO8)
      |=> (((d_o[0] | d_o[1] | d_o[2]) & ~$past(mask_i)) == '0));
endmodule

// File: rtl/color_lookup_path.sv
module color_lookup_path
  import pxl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PIX_W-1:0]  pix_r_i,
  input  logic [PIX_W-1:0]  pix_g_i,
  input  logic [PIX_W-1:0]  pix_b_i,
  input  logic [OVL_W-1:0]  ovl_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [PIX_W-1:0]  wr_data_i,
  output logic [PIX_W-1:0]  col_r_o,
  output logic [PIX_W-1:0]  col_g_o,
  output logic [PIX_W-1:0]  col_b_o
);
  logic [NCH-1:0]   pal_we;
  logic [PIX_W-1:0] mask;
  logic [2:0]       mode;
  logic [1:0]       port_sel;
  rgb_t [NOVL-1:0]  ovl_col;
  rgb_t             d_s1, pal_rd, col_q;
  logic             use_pal_s1;
  logic [OVL_W-1:0] ovl_s1;

  pxl_host_regs i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .pal_we_o(pal_we), .mask_o(mask), .mode_o(mode),
    .port_sel_o(port_sel), .ovl_o(ovl_col)
  );

  pxl_format i_fmt (
    .clk_i, .rst_ni, .r_i(pix_r_i), .g_i(pix_g_i), .b_i(pix_b_i),
    .ovl_i, .mode_i(mode), .port_sel_i(port_sel), .mask_i(mask),
    .d_o(d_s1), .use_pal_o(use_pal_s1), .ovl_o(ovl_s1)
  );

  pxl_palette i_pal (
    .clk_i, .we_i(pal_we), .wa_i(wr_addr_i[PIX_W-1:0]), .wd_i(wr_data_i),
    .ra_i(d_s1), .rd_o(pal_rd)
  );

  // Stage 2: overlay beats palette beats bypass
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= '0;
    else if (ovl_s1 != '0) col_q <= ovl_col[ovl_s1];
    else if (use_pal_s1) col_q <= pal_rd;
    else col_q <= d_s1;
  end

  assign col_r_o = col_q[0];
  assign col_g_o = col_q[1];
  assign col_b_o = col_q[2];

  a_r9_overlay_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovl_s1 != '0) |=> ({col_b_o, col_g_o, col_r_o} == $past(ovl_col[ovl_s1])));
endmodule

// File: tb/test_color_lookup_path.sv
module test_color_lookup_path;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pr = '0, pg = '0, pb = '0;
  logic [3:0] ov = '0;
  logic       we = 1'b0;
  logic [9:0] wa = '0;
  logic [7:0] wd = '0;
  logic [7:0] cr, cg, cb;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  color_lookup_path i_color_lookup_path (
    .clk_i(clk), .rst_ni(rst_n), .pix_r_i(pr), .pix_g_i(pg), .pix_b_i(pb),
    .ovl_i(ov), .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .col_r_o(cr), .col_g_o(cg), .col_b_o(cb)
  );

  function automatic logic [7:0] pal(int c, int a);
    return 8'((a * 7 + c * 61 + 3) & 255);
  endfunction

  task automatic chk(string req, logic [7:0] er, logic [7:0] eg, logic [7:0] eb);
    checks++;
    if (cr !== er || cg !== eg || cb !== eb) begin
      errors++;
      $display("FAIL %s: got %h %h %h expected %h %h %h", req, cr, cg, cb, er, eg, eb);
    end
  endtask

  task automatic host_wr(logic [9:0] a, logic [7:0] d);
    we = 1'b1; wa = a; wd = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_ctrl(logic [1:0] sel, logic [2:0] mode);
    host_wr(10'h301, {sel, 3'b000, mode});
  endtask

  task automatic px(logic [7:0] r, logic [7:0] g, logic [7:0] b, logic [3:0] o);
    pr = r; pg = g; pb = b; ov = o;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset_latency;
    chk("R1 reset", 8'h00, 8'h00, 8'h00);
    set_ctrl(2'd0, 3'd1);
    px(8'h11, 8'h22, 8'h33, 4'd0);
    pr = 8'h44; pg = 8'h55; pb = 8'h66;
    @(posedge clk); @(negedge clk);
    chk("R1 not after one edge", 8'h11, 8'h22, 8'h33);
    @(posedge clk); @(negedge clk);
    chk("R1 after two edges", 8'h44, 8'h55, 8'h66);
  endtask

  task automatic t_tc24;
    set_ctrl(2'd0, 3'd0);
    px(8'h12, 8'h34, 8'hFE, 4'd0);
    chk("R2 tc24", pal(0, 'h12), pal(1, 'h34), pal(2, 'hFE));
    host_wr(10'h300, 8'h0F);
    px(8'h12, 8'h34, 8'hFE, 4'd0);
    chk("R8 mask tc24", pal(0, 'h02), pal(1, 'h04), pal(2, 'h0E));
  endtask

  task automatic t_byp24;
    set_ctrl(2'd0, 3'd1);
    px(8'h12, 8'h34, 8'hFE, 4'd0);
    chk("R3 R8 byp24 ignores mask", 8'h12, 8'h34, 8'hFE);
  endtask

  task automatic t_pseudo8;
    set_ctrl(2'd1, 3'd2);
    px(8'hA5, 8'h3C, 8'h77, 4'd0);
    chk("R4 pseudo8 green", pal(0, 'h0C), pal(1, 'h0C), pal(2, 'h0C));
    set_ctrl(2'd2, 3'd2);
    px(8'hA5, 8'h3C, 8'h77, 4'd0);
    chk("R4 pseudo8 blue", pal(0, 'h07), pal(1, 'h07), pal(2, 'h07));
    set_ctrl(2'd0, 3'd2);
    px(8'hA5, 8'h3C, 8'h77, 4'd0);
    chk("R4 pseudo8 red", pal(0, 'h05), pal(1, 'h05), pal(2, 'h05));
    host_wr(10'h300, 8'hFF);
    set_ctrl(2'd3, 3'd2);
    px(8'hA5, 8'h3C, 8'h77, 4'd0);
    chk("R4 pseudo8 sel11 blue", pal(0, 'h77), pal(1, 'h77), pal(2, 'h77));
  endtask

  task automatic t_byp8;
    host_wr(10'h300, 8'h0F);
    set_ctrl(2'd1, 3'd3);
    px(8'h00, 8'hBB, 8'h00, 4'd0);
    chk("R5 byp8 green", 8'hA0, 8'hC0, 8'hC0);
    set_ctrl(2'd0, 3'd3);
    px(8'hE4, 8'hFF, 8'hFF, 4'd0);
    chk("R5 byp8 red", 8'hE0, 8'h20, 8'h00);
  endtask

  task automatic t_15bit;
    set_ctrl(2'd0, 3'd5);
    px(8'hFF, 8'h00, 8'hFF, 4'd0);
    chk("R6 byp15 msb ignored", 8'hF8, 8'hC0, 8'h00);
    px(8'h2A, 8'hB5, 8'h00, 4'd0);
    chk("R6 byp15 fields", 8'h50, 8'hA8, 8'hA8);
    set_ctrl(2'd0, 3'd4);
    px(8'h2A, 8'hB5, 8'h00, 4'd0);
    chk("R7 pal15", pal(0, 'hEA), pal(1, 'hF5), pal(2, 'hF5));
    px(8'h80, 8'h00, 8'hFF, 4'd0);
    chk("R7 pal15 base 224", pal(0, 'hE0), pal(1, 'hE0), pal(2, 'hE0));
  endtask

  task automatic t_overlay;
    host_wr(10'h314, 8'h11); host_wr(10'h315, 8'h22); host_wr(10'h316, 8'h33);
    host_wr(10'h33C, 8'hC1); host_wr(10'h33D, 8'hC2); host_wr(10'h33E, 8'hC3);
    host_wr(10'h300, 8'hFF);
    set_ctrl(2'd0, 3'd0);
    px(8'h12, 8'h34, 8'hFE, 4'd5);
    chk("R9 overlay 5 tc24", 8'h11, 8'h22, 8'h33);
    set_ctrl(2'd0, 3'd5);
    px(8'h2A, 8'hB5, 8'h00, 4'd15);
    chk("R9 overlay 15 byp15", 8'hC1, 8'hC2, 8'hC3);
    px(8'h2A, 8'hB5, 8'h00, 4'd0);
    chk("R9 overlay 0 passes", 8'h50, 8'hA8, 8'hA8);
  endtask

  task automatic t_host;
    set_ctrl(2'd0, 3'd0);
    host_wr(10'h040, 8'h99);
    px(8'h40, 8'h00, 8'h00, 4'd0);
    chk("R10 palette write next pixel", 8'h99, pal(1, 0), pal(2, 0));
    host_wr(10'h340, 8'h00);
    host_wr(10'h381, 8'h01);
    px(8'h12, 8'h34, 8'hFE, 4'd0);
    chk("R10 0x340+ ignored", pal(0, 'h12), pal(1, 'h34), pal(2, 'hFE));
  endtask

  task automatic t_reserved;
    set_ctrl(2'd0, 3'd6);
    px(8'h5A, 8'hC3, 8'h0F, 4'd0);
    chk("R11 mode 6", 8'h5A, 8'hC3, 8'h0F);
    set_ctrl(2'd0, 3'd7);
    px(8'h01, 8'h80, 8'hFF, 4'd0);
    chk("R11 mode 7", 8'h01, 8'h80, 8'hFF);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_latency();
    for (int c = 0; c < 3; c++)
      for (int a = 0; a < 256; a++) host_wr(10'(c * 256 + a), pal(c, a));
    t_tc24();
    t_byp24();
    t_pseudo8();
    t_byp8();
    t_15bit();
    t_overlay();
    t_host();
    t_reserved();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule